// File: doc/BRIEF.md
# Read-Modify-Write Compound ALU Sequencer

This block runs one compound instruction that changes a memory byte and then combines the changed byte with the accumulator. A one-cycle `start` hands over the opcode, the operand bytes, the accumulator, the X index and the incoming carry and overflow flags. The block then works out the effective address and reads the byte. It writes the unchanged byte back first and the modified byte second. When the sequence ends it reports the new accumulator and the new flags. The memory step always completes before the accumulator step starts. A carry produced by a rotate feeds the add that follows it.

Six families are supported. Shift-left/OR, rotate-left/AND, shift-right/XOR and rotate-right/add each modify the byte and then fold it into the accumulator. Decrement/compare and increment/subtract-with-borrow work the same way. Each family has four addressing forms: page zero, page zero indexed by X, absolute, and absolute indexed by X. All arithmetic is binary. A surrounding core supplies the operands, owns the memory port and reads the results when `done` pulses.

Top module: `rmw_alu_seq`

## Requirements
- R1: An opcode is accepted only if its low three bits are 111 and bits 7:5 are 000, 001, 010, 011, 110 or 111. Those bit 7:5 values select shift-left/OR, rotate-left/AND, shift-right/XOR, rotate-right/add, decrement/compare and increment/subtract. Any other opcode on `start` causes no bus activity, no `done`, and no change to the outputs.
- R2: Bit 4 selects indexing and bit 3 selects absolute addressing. `done` is high in cycle N after the cycle in which `start` is sampled. N is 5 for page zero, 6 for page zero indexed, 6 for absolute and 7 for absolute indexed. An indexed absolute access always takes its extra cycle.
- R3: The bus does one read of the effective address. In the next cycle it writes the byte just read back to that address. In the cycle after that it writes the modified byte to the same address. `busRd` and `busWr` are never high together.
- R4: For page zero the address is the low operand byte. For page zero indexed it is the low operand byte plus X, wrapped within page zero. For absolute it is {high, low}. For absolute indexed it is {high, low} plus X, with the carry going into the high byte.
- R5: Shift-left/OR writes M<<1, sets C from the old bit 7, sets A = A | M', sets N and Z from the new A, and keeps V.
- R6: Rotate-left/AND writes {M[6:0], C}, sets C from the old bit 7, sets A = A & M', sets N and Z from A, and keeps V.
- R7: Shift-right/XOR writes M>>1, sets C from the old bit 0, sets A = A ^ M', sets N and Z from A, and keeps V.
- R8: Rotate-right/add writes {C, M[7:1]}. It then sets A = A + M' + c, where c is the old bit 0 of M, and sets N, Z, C and V by the rules of a binary add.
- R9: Decrement/compare writes M-1 and leaves A unchanged. C is set when A >= M' unsigned. Z is set exactly when A == M'. N is bit 7 of A - M'. V keeps its input value.
- R10: Increment/subtract writes M+1 and sets A = A - M' - (1 - C). N, Z and V follow a binary subtract, and C is set when no borrow occurs.
- R11: `done` is a one-cycle pulse. `accOut` and `flagsOut` (packed {N,V,Z,C}) hold until the next accepted instruction finishes. A `start` that arrives while an instruction is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| opcode | input | 8 | Compound opcode |
| opLo | input | DW | Low operand byte |
| opHi | input | AW-DW | High operand byte (absolute forms) |
| regA | input | DW | Accumulator value |
| regX | input | DW | X index value |
| carryIn | input | 1 | Incoming carry flag |
| ovfIn | input | 1 | Incoming overflow flag |
| busAddr | output | AW | Memory address |
| busRd | output | 1 | Memory read strobe; data returned the same cycle |
| busWr | output | 1 | Memory write strobe |
| busWdata | output | DW | Write data |
| busRdata | input | DW | Read data |
| done | output | 1 | Result-valid pulse |
| accOut | output | DW | New accumulator |
| flagsOut | output | 4 | New flags {N,V,Z,C} |

## Verification
The bench sweeps every byte value through all six families. For each value it tries both carry inputs and rotates through all four addressing forms. It computes the results with signed and unsigned integer arithmetic.

Specific cases target the index wrap within page zero and the carry into the high byte. A design that lets the page-zero index spill into page one, or drops the high-byte carry, writes to the wrong location. Another case is the rotate carry feeding the add; a design that uses the stale input carry there gives sums that are off by one. The decrement/compare loop test (A = 0xA5 against a byte that becomes 0xA5) catches a compare against the pre-decrement value. Other cases check that rejected opcodes and mid-instruction starts leave both the bus and the held results untouched.

// File: rtl/rmw_seq_pkg.sv
package rmw_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LO, ST_HI, ST_IDX, ST_RD, ST_WOLD, ST_WNEW, ST_FIN
  } seqState_t;

  // family code = opcode[7:5]
  typedef enum logic [2:0] {
    F_SLO = 3'd0, F_RLA = 3'd1, F_SRE = 3'd2, F_RRA = 3'd3,
    F_BAD4 = 3'd4, F_BAD5 = 3'd5, F_DCP = 3'd6, F_ISB = 3'd7
  } family_t;

  typedef struct packed {
    logic capture;   // latch operands at accept
    logic grabOld;   // latch read data
    logic writeNew;  // drive modified byte, commit results
  } dpStrobe_t;

endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import rmw_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] opcode,
  output dpStrobe_t  strb,
  output logic       busRd,
  output logic       busWr,
  output logic       done
);

  seqState_t state, nxt;
  logic absQ, idxQ;
  logic opValid;

  // R1: low bits 111, family not 100/101
  assign opValid = (opcode[2:0] == 3'b111) && !(opcode[7] && !opcode[6]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      absQ  <= 1'b0;
      idxQ  <= 1'b0;
    end else begin
      state <= nxt;
      if (strb.capture) begin
        absQ <= opcode[3];
        idxQ <= opcode[4];
      end
    end
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start && opValid) nxt = ST_LO;
      ST_LO:   nxt = absQ ? ST_HI : (idxQ ? ST_IDX : ST_RD);
      ST_HI:   nxt = idxQ ? ST_IDX : ST_RD;
      ST_IDX:  nxt = ST_RD;
      ST_RD:   nxt = ST_WOLD;
      ST_WOLD: nxt = ST_WNEW;
      ST_WNEW: nxt = ST_FIN;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign strb.capture  = (state == ST_IDLE) && start && opValid;
  assign strb.grabOld  = (state == ST_RD);
  assign strb.writeNew = (state == ST_WNEW);
  assign busRd = (state == ST_RD);
  assign busWr = (state == ST_WOLD) || (state == ST_WNEW);
  assign done  = (state == ST_FIN);

endmodule

// File: rtl/rmw_dpath.sv
module rmw_dpath
  import rmw_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [2:0]       famIn,
  input  logic             absIn,
  input  logic             idxIn,
  input  logic [DW-1:0]    opLo,
  input  logic [AW-DW-1:0] opHi,
  input  logic [DW-1:0]    regA,
  input  logic [DW-1:0]    regX,
  input  logic             carryIn,
  input  logic             ovfIn,
  input  logic [DW-1:0]    busRdata,
  output logic [AW-1:0]    busAddr,
  output logic [DW-1:0]    busWdata,
  output logic [DW-1:0]    accOut,
  output logic [3:0]       flagsOut
);

  localparam int HI_W = AW - DW;
  localparam logic [DW-1:0] ONE = DW'(1);

  family_t famQ;
  logic absQ, idxQ, cQ, vQ;
  logic [DW-1:0] loQ, aQ, xQ, oldQ;
  logic [HI_W-1:0] hiQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      famQ <= F_SLO; absQ <= 1'b0; idxQ <= 1'b0; cQ <= 1'b0; vQ <= 1'b0;
      loQ <= '0; hiQ <= '0; aQ <= '0; xQ <= '0; oldQ <= '0;
    end else begin
      if (strb.capture) begin
        famQ <= family_t'(famIn);
        absQ <= absIn; idxQ <= idxIn;
        loQ <= opLo; hiQ <= opHi; aQ <= regA; xQ <= regX;
        cQ <= carryIn; vQ <= ovfIn;
      end
      if (strb.grabOld) oldQ <= busRdata;
    end
  end

  // Effective address: page-zero index wraps, absolute index carries (R4)
  logic [DW-1:0] zpSum;
  logic [AW-1:0] absBase;
  assign zpSum   = loQ + xQ;
  assign absBase = {hiQ, loQ};
  always_comb begin
    if (absQ) busAddr = idxQ ? absBase + {{HI_W{1'b0}}, xQ} : absBase;
    else      busAddr = {{HI_W{1'b0}}, idxQ ? zpSum : loQ};
  end

  // Memory modify step
  logic [DW-1:0] newVal;
  logic shC;
  always_comb begin
    newVal = oldQ;
    shC    = cQ;
    unique case (famQ)
      F_SLO: begin newVal = {oldQ[DW-2:0], 1'b0}; shC = oldQ[DW-1]; end
      F_RLA: begin newVal = {oldQ[DW-2:0], cQ};   shC = oldQ[DW-1]; end
      F_SRE: begin newVal = {1'b0, oldQ[DW-1:1]}; shC = oldQ[0]; end
      F_RRA: begin newVal = {cQ, oldQ[DW-1:1]};   shC = oldQ[0]; end
      F_DCP: newVal = oldQ - ONE;
      F_ISB: newVal = oldQ + ONE;
      default: ;
    endcase
  end

  assign busWdata = strb.writeNew ? newVal : oldQ;

  // Shared adder: add for RRA, A + ~M + cin for compare and subtract
  logic [DW-1:0] addend;
  logic cin, ovf;
  logic [DW:0] sum;
  always_comb begin
    addend = (famQ == F_RRA) ? newVal : ~newVal;
    cin    = (famQ == F_RRA) ? shC : ((famQ == F_DCP) ? 1'b1 : cQ);
    sum    = {1'b0, aQ} + {1'b0, addend} + {{DW{1'b0}}, cin};
    ovf    = (aQ[DW-1] == addend[DW-1]) && (sum[DW-1] != aQ[DW-1]);
  end

  logic [DW-1:0] resA, flagSrc;
  logic resC, resV;
  always_comb begin
    resA = aQ; resC = shC; resV = vQ; flagSrc = aQ;
    unique case (famQ)
      F_SLO: resA = aQ | newVal;
      F_RLA: resA = aQ & newVal;
      F_SRE: resA = aQ ^ newVal;
      F_RRA, F_ISB: begin resA = sum[DW-1:0]; resC = sum[DW]; resV = ovf; end
      F_DCP: resC = sum[DW];
      default: ;
    endcase
    flagSrc = (famQ == F_DCP) ? sum[DW-1:0] : resA;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accOut   <= '0;
      flagsOut <= '0;
    end else if (strb.writeNew) begin
      accOut   <= resA;
      flagsOut <= {flagSrc[DW-1], resV, (flagSrc == '0), resC};
    end
  end

endmodule

// File: rtl/rmw_alu_seq.sv
module rmw_alu_seq
  import rmw_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [DW-1:0]    opLo,
  input  logic [AW-DW-1:0] opHi,
  input  logic [DW-1:0]    regA,
  input  logic [DW-1:0]    regX,
  input  logic             carryIn,
  input  logic             ovfIn,
  output logic [AW-1:0]    busAddr,
  output logic             busRd,
  output logic             busWr,
  output logic [DW-1:0]    busWdata,
  input  logic [DW-1:0]    busRdata,
  output logic             done,
  output logic [DW-1:0]    accOut,
  output logic [3:0]       flagsOut
);

  dpStrobe_t strb;

  rmw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .strb(strb), .busRd(busRd), .busWr(busWr), .done(done)
  );

  rmw_dpath #(.DW(DW), .AW(AW)) i_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .famIn(opcode[7:5]), .absIn(opcode[3]), .idxIn(opcode[4]),
    .opLo(opLo), .opHi(opHi), .regA(regA), .regX(regX),
    .carryIn(carryIn), .ovfIn(ovfIn), .busRdata(busRdata),
    .busAddr(busAddr), .busWdata(busWdata),
    .accOut(accOut), .flagsOut(flagsOut)
  );

endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          busRd,
  input logic          busWr,
  input logic [AW-1:0] busAddr,
  input logic [DW-1:0] busWdata,
  input logic [DW-1:0] busRdata,
  input logic          done
);

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  a_r3_echo_old: assert property (@(posedge clk) disable iff (!rstN)
    $past(busRd) |-> (busWr && busWdata == $past(busRdata) && busAddr == $past(busAddr)));

  a_r3_new_same_addr: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busWr) && $past(busRd, 2)) |-> (busWr && $stable(busAddr)));

  a_r2_done_after_write: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($past(busWr) && !busWr && !busRd));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind rmw_alu_seq rmw_seq_chk #(.DW(DW), .AW(AW)) i_chk (
  .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .done(done)
);

// File: tb/test_rmw_alu_seq.sv
module test_rmw_alu_seq;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00, opLo = 8'h00, opHi = 8'h00, regA = 8'h00, regX = 8'h00;
  logic carryIn = 1'b0, ovfIn = 1'b0;
  logic [15:0] busAddr;
  logic busRd, busWr, done;
  logic [7:0] busWdata, busRdata, accOut, memVal;
  logic [3:0] flagsOut;

  int nChk = 0, nErr = 0, cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign busRdata = busRd ? memVal : 8'h00;

  rmw_alu_seq i_rmw_alu_seq (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .opLo(opLo), .opHi(opHi),
    .regA(regA), .regX(regX), .carryIn(carryIn), .ovfIn(ovfIn),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .done(done), .accOut(accOut), .flagsOut(flagsOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nErr++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      finishRun();
    end
  end

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  logic [7:0] lastA;
  logic [3:0] lastF;

  task automatic runOp(input logic [7:0] op, lo, hi, a, x, input bit c, v,
                       input logic [7:0] m, input bit disturb);
    int n, expAddr, newM, expA, nf, vf, zf, cf, cyc, rdCnt, rdAddr, rdCyc, wrCnt;
    int wAddr[2], wData[2], wCyc[2];
    string tag;
    int fam;
    fam = op[7:5];
    unique case ({op[4], op[3]})
      2'b00: begin n = 5; expAddr = lo; end
      2'b10: begin n = 6; expAddr = (lo + x) % 256; end
      2'b01: begin n = 6; expAddr = hi * 256 + lo; end
      default: begin n = 7; expAddr = (hi * 256 + lo + x) % 65536; end
    endcase
    expA = a; vf = v; cf = c; newM = m;
    case (fam)
      0: begin tag = "R5 shl/or";  newM = (m * 2) % 256; cf = m / 128; expA = a | newM; end
      1: begin tag = "R6 rol/and"; newM = (m * 2) % 256 + c; cf = m / 128; expA = a & newM; end
      2: begin tag = "R7 shr/xor"; newM = m / 2; cf = m % 2; expA = a ^ newM; end
      3: begin
        int s, ss;
        tag = "R8 ror/add"; newM = m / 2 + 128 * c;
        s = a + newM + (m % 2); ss = sgn(a) + sgn(newM) + (m % 2);
        expA = s % 256; cf = (s > 255); vf = (ss > 127 || ss < -128);
      end
      6: begin tag = "R9 dec/cmp"; newM = (m + 255) % 256; cf = (a >= newM); end
      default: begin
        int d, sd;
        tag = "R10 inc/sub"; newM = (m + 1) % 256;
        d = a - newM - (1 - c); sd = sgn(a) - sgn(newM) - (1 - c);
        expA = (d + 512) % 256; cf = (d >= 0); vf = (sd > 127 || sd < -128);
      end
    endcase
    if (fam == 6) begin
      int r; r = (a - newM + 256) % 256;
      nf = r / 128; zf = (a == newM);
    end else begin
      nf = expA / 128; zf = (expA == 0);
    end

    @(negedge clk);
    opcode = op; opLo = lo; opHi = hi; regA = a; regX = x; carryIn = c; ovfIn = v;
    memVal = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1; rdCnt = 0; rdAddr = -1; rdCyc = -1; wrCnt = 0;
    while (!done && cyc < 20) begin
      if (disturb && cyc == 2) begin
        start = 1'b1; opcode = 8'h0F; opLo = 8'h55; opHi = 8'h66; regA = 8'h00; regX = 8'h11;
      end else if (disturb && cyc == 3) begin
        start = 1'b0;
      end
      if (busRd) begin rdCnt++; rdAddr = busAddr; rdCyc = cyc; end
      if (busWr) begin
        if (wrCnt < 2) begin wAddr[wrCnt] = busAddr; wData[wrCnt] = busWdata; wCyc[wrCnt] = cyc; end
        wrCnt++;
      end
      @(negedge clk);
      cyc++;
    end
    chk(cyc == n, "R2 cycles", cyc, n);
    chk(rdCnt == 1 && rdAddr == expAddr, "R4 address", rdAddr, expAddr);
    chk(wrCnt == 2, "R3 write count", wrCnt, 2);
    if (wrCnt == 2) begin
      chk(wCyc[0] == rdCyc + 1 && wCyc[1] == rdCyc + 2, "R3 write order", wCyc[0], rdCyc + 1);
      chk(wAddr[0] == expAddr && wAddr[1] == expAddr, "R3 write addr", wAddr[1], expAddr);
      chk(wData[0] == m, "R3 old echo", wData[0], m);
      chk(wData[1] == newM, {tag, " mem"}, wData[1], newM);
    end
    chk(accOut == expA[7:0], {tag, " A"}, accOut, expA);
    chk(flagsOut == {nf[0], vf[0], zf[0], cf[0]}, {tag, " flags"}, flagsOut,
        {nf[0], vf[0], zf[0], cf[0]});
    lastA = accOut; lastF = flagsOut;
    @(negedge clk);
    chk(!done, "R11 done pulse", done, 0);
  endtask

  task automatic tryBad(input logic [7:0] op);
    int act;
    act = 0;
    @(negedge clk);
    opcode = op; opLo = 8'h12; opHi = 8'h34; regA = 8'hFF; regX = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (busRd || busWr || done) act++;
      @(negedge clk);
    end
    chk(act == 0, "R1 rejected opcode bus", act, 0);
    chk(accOut == lastA && flagsOut == lastF, "R1 rejected opcode outputs", {accOut, flagsOut},
        {lastA, lastF});
  endtask

  initial begin
    memVal = 8'h00;
    repeat (4) @(negedge clk);
    chk(accOut == 8'h00 && flagsOut == 4'h0 && !done && !busRd && !busWr,
        "R11 reset state", {accOut, flagsOut}, 0);
    rstN = 1'b1;
    // R9 loop-exit case: counter 0xA6 decrements to 0xA5
    runOp(8'hCF, 8'h00, 8'h16, 8'hA5, 8'h00, 1'b0, 1'b0, 8'hA6, 1'b0);
    chk(flagsOut[1] == 1'b1 && accOut == 8'hA5, "R9 loop Z", flagsOut, 4'b0011);
    runOp(8'hCF, 8'h00, 8'h16, 8'hA5, 8'h00, 1'b0, 1'b0, 8'hA7, 1'b0);
    chk(flagsOut[1] == 1'b0, "R9 loop not equal", flagsOut[1], 0);
    // R4 page-zero wrap and high-byte carry
    runOp(8'h17, 8'hF0, 8'h77, 8'h01, 8'h20, 1'b0, 1'b0, 8'h81, 1'b0);
    runOp(8'h1F, 8'hF0, 8'h12, 8'h01, 8'h20, 1'b1, 1'b1, 8'h81, 1'b0);
    runOp(8'hFF, 8'hFF, 8'hFF, 8'h80, 8'h01, 1'b0, 1'b0, 8'hFF, 1'b0);
    // R8 carry from rotate feeds add, R11 mid-op start ignored
    runOp(8'h67, 8'h10, 8'h00, 8'h7F, 8'h00, 1'b0, 1'b0, 8'h01, 1'b1);
    runOp(8'hE7, 8'h10, 8'h00, 8'h80, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1);
    // R1 rejected opcodes
    tryBad(8'h87); tryBad(8'hB7); tryBad(8'h9F); tryBad(8'h05); tryBad(8'hAF);
    // sweep over families, byte values, carry and modes
    for (int f = 0; f < 6; f++) begin
      for (int mi = 0; mi < 256; mi++) begin
        for (int c = 0; c < 2; c++) begin
          logic [2:0] fb;
          logic [1:0] md;
          logic [7:0] mv;
          fb = (f < 4) ? 3'(f) : 3'(f + 2);
          md = 2'((mi + c) % 4);
          mv = 8'(mi);
          runOp({fb, md[1], md[0], 3'b111}, 8'(mi * 7 + 3), 8'(mi ^ 8'h5A),
                8'(mi * 37 + 13), 8'(mi * 13 + 1), c[0], mv[1], mv, 1'b0);
        end
      end
    end
    finishRun();
  end

endmodule